// File: doc/BRIEF.md
# Translation Lookaside Buffer with Page-Table Refill

This block is a small fully associative translation cache. It maps a virtual page number to a physical page number. A requester presents a page number together with a write flag. If a stored entry matches, the physical page comes back on the next cycle. If none matches, the block reads the page-table entry for that page over a single request/acknowledge memory port. A resident page is loaded into the cache and the lookup is repeated. A non-resident page produces a page-fault response, and nothing is loaded.

Each cached entry carries a reference bit and a dirty bit. They are the only fields that change after an entry is loaded: any successful translation sets the reference bit, and a translation with the write flag also sets the dirty bit. These two bits reach the page table only when their entry is displaced by a new fill. At that point a write transaction copies the two bits, and only those bits, back to the page-table entry the cache entry came from. The victim is the lowest-numbered empty entry, or, when every entry is in use, the entry named by a round-robin pointer.

Top module: `tlb_xlate`

## Requirements
- R1: An accepted request whose page number matches a valid entry gives `rsp_valid` on the following cycle, with `rsp_hit`=1, `rsp_fault`=0 and the stored `rsp_ppn`, and starts no page-table transaction.
- R2: On a miss, the block reads the page-table word at address = page number. That word is {resident at bit PPN_W+2, reference at bit PPN_W+1, dirty at bit PPN_W, physical page in bits PPN_W-1:0}. If the resident bit is 1, the block loads an entry carrying that physical page and those reference/dirty bits, repeats the lookup, and responds with `rsp_hit`=0, `rsp_fault`=0 and the physical page.
- R3: If the resident bit read on a miss is 0, the response has `rsp_fault`=1 and `rsp_hit`=0. No entry is loaded, so a later request for the same page misses again, and no page-table write takes place.
- R4: Every successful translation (hit, or the repeat lookup after a fill) sets the entry's reference bit. If the request's write flag is 1, it also sets the dirty bit.
- R5: A page-table write (`pt_we`=1) happens only when a fill displaces a valid entry. It goes to that entry's page number with `pt_wdata[1]`=reference and `pt_wdata[0]`=dirty, and the page table updates only those two bits of the word.
- R6: The fill target is the lowest-numbered invalid entry. If all entries are valid, it is the entry named by a round-robin pointer. That pointer starts at 0 after reset and advances by one, wrapping, each time it is used.
- R7: `req_ready` is low from the cycle after a miss is accepted until the response is given, and requests presented during that time are ignored.
- R8: A synchronous active-low reset invalidates all entries without any page-table write. After reset `req_ready`=1 and `rsp_valid`=0.
- R9: A page-table request holds `pt_req`, `pt_we` and `pt_addr` steady until the cycle in which `pt_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translate request present |
| req_vpn | input | VPN_W | Virtual page number to translate |
| req_write | input | 1 | Request is a store (sets dirty bit) |
| req_ready | output | 1 | Block can accept a request this cycle |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_ppn | output | PPN_W | Translated physical page |
| rsp_hit | output | 1 | Served from the cache without a table read |
| rsp_fault | output | 1 | Page not resident |
| pt_req | output | 1 | Page-table transaction request |
| pt_we | output | 1 | Transaction is a reference/dirty write-back |
| pt_addr | output | VPN_W | Page-table index (page number) |
| pt_wdata | output | 2 | {reference, dirty} for write-back |
| pt_ack | input | 1 | Page-table transaction complete |
| pt_rdata | input | PPN_W+3 | Page-table word read |

## Verification
The bench builds the block with four entries, 8-bit page numbers and 6-bit physical pages. Random page numbers are drawn from only twelve values, so hits, refills, displacement of entries that have been referenced or written, and wrap-around of the round-robin pointer all occur often. One page number in five is non-resident, which makes faults on repeated pages common. A reset in the middle of the run, with dirty entries held in the cache, shows that invalidation writes nothing back.

// File: rtl/tlbx_pkg.sv
// Shared definitions for the translation cache.
// Assumes: nothing beyond the enclosing design's parameters.
package tlbx_pkg;

    // Miss-service sequence of the controller
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,   // accepting requests
        ST_READ  = 3'd1,   // reading the page-table word
        ST_EVICT = 3'd2,   // writing reference/dirty of the victim back
        ST_FILL  = 3'd3,   // loading the new entry
        ST_RETRY = 3'd4    // repeating the lookup after a fill
    } tlbx_state_e;

    // Width of the write-back data: {reference, dirty}
    localparam int unsigned WB_W = 2;

endpackage

// File: rtl/tlbx_match.sv
// Fully associative tag comparator.
// Compares a key with every stored page number and reports the lowest
// matching valid slot. Assumes at most one valid slot matches a key.
module tlbx_match #(
    parameter int unsigned N     = 4,
    parameter int unsigned VPN_W = 8,
    localparam int unsigned IW   = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]            valid_vec,
    input  logic [N-1:0][VPN_W-1:0] vpn_vec,
    input  logic [VPN_W-1:0]        key,
    output logic                    hit,
    output logic [IW-1:0]           hit_idx
);

    logic [N-1:0] eq_vec;

    // Per-slot comparators
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign eq_vec[g] = valid_vec[g] && (vpn_vec[g] == key);
    end

    // Encode the matching slot, lowest index preferred
    always_comb begin
        hit     = |eq_vec;
        hit_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (eq_vec[i]) hit_idx = IW'(i);
        end
    end

endmodule

// File: rtl/tlbx_victim.sv
// Fill-target selector.
// Picks the lowest invalid slot; when every slot is valid it uses a
// round-robin pointer that moves on only when it was the one used.
// Assumes 'advance' is pulsed once per fill that displaced a valid slot.
module tlbx_victim #(
    parameter int unsigned N   = 4,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  valid_vec,
    input  logic          advance,
    output logic [IW-1:0] victim,
    output logic          victim_free
);

    logic [IW-1:0] rr_q;

    // Choose the first empty slot, else the pointer
    always_comb begin
        victim_free = 1'b0;
        victim      = rr_q;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                victim_free = 1'b1;
                victim      = IW'(i);
            end
        end
    end

    // Round-robin pointer, wrapping at N-1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (advance) begin
            rr_q <= (rr_q == IW'(N - 1)) ? '0 : rr_q + IW'(1);
        end
    end

endmodule

// File: rtl/tlb_xlate.sv
// Fully associative translation cache with page-table refill.
// Hits respond one cycle after acceptance. A miss reads the page-table
// word, raises a fault if the page is not resident, otherwise writes the
// victim's reference/dirty bits back (when the victim is valid), loads the
// entry and repeats the lookup. Only one request is in service at a time.
// Assumes the page table answers every request with a one-cycle pt_ack.
module tlb_xlate #(
    parameter int unsigned N     = 4,
    parameter int unsigned VPN_W = 8,
    parameter int unsigned PPN_W = 6,
    localparam int unsigned IW    = (N > 1) ? $clog2(N) : 1,
    localparam int unsigned PTE_W = PPN_W + 3,
    localparam int unsigned RES_B = PPN_W + 2,
    localparam int unsigned REF_B = PPN_W + 1,
    localparam int unsigned DRT_B = PPN_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [VPN_W-1:0]         req_vpn,
    input  logic                     req_write,
    output logic                     req_ready,
    output logic                     rsp_valid,
    output logic [PPN_W-1:0]         rsp_ppn,
    output logic                     rsp_hit,
    output logic                     rsp_fault,
    output logic                     pt_req,
    output logic                     pt_we,
    output logic [VPN_W-1:0]         pt_addr,
    output logic [tlbx_pkg::WB_W-1:0] pt_wdata,
    input  logic                     pt_ack,
    input  logic [PTE_W-1:0]         pt_rdata
);

    import tlbx_pkg::*;

    // Entry storage
    logic [N-1:0]            e_val;
    logic [N-1:0]            e_ref;
    logic [N-1:0]            e_drt;
    logic [N-1:0][VPN_W-1:0] e_vpn;
    logic [N-1:0][PPN_W-1:0] e_ppn;

    // Controller state and captured miss context
    tlbx_state_e      st_q;
    logic [VPN_W-1:0] cap_vpn_q;
    logic             cap_wr_q;
    logic [IW-1:0]    vic_q;
    logic             vic_free_q;
    logic [PTE_W-1:0] pte_q;

    // Lookup and selection wires
    logic [VPN_W-1:0] key;
    logic             m_hit;
    logic [IW-1:0]    m_idx;
    logic [IW-1:0]    v_idx;
    logic             v_free;
    logic             accept;
    logic             lookup_ok;
    logic             wr_flag;
    logic             rr_advance;

    // Lookup key: incoming request, or the captured one on the retry pass
    always_comb begin
        key     = (st_q == ST_RETRY) ? cap_vpn_q : req_vpn;
        wr_flag = (st_q == ST_RETRY) ? cap_wr_q  : req_write;
    end

    assign req_ready  = (st_q == ST_IDLE);
    assign accept     = req_ready && req_valid;
    assign lookup_ok  = (accept || (st_q == ST_RETRY)) && m_hit;
    assign rr_advance = (st_q == ST_FILL) && !vic_free_q;

    tlbx_match #(.N(N), .VPN_W(VPN_W)) match_i (
        .valid_vec (e_val),
        .vpn_vec   (e_vpn),
        .key       (key),
        .hit       (m_hit),
        .hit_idx   (m_idx)
    );

    tlbx_victim #(.N(N)) victim_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid_vec   (e_val),
        .advance     (rr_advance),
        .victim      (v_idx),
        .victim_free (v_free)
    );

    // Page-table port driven from the controller state
    always_comb begin
        pt_req   = (st_q == ST_READ) || (st_q == ST_EVICT);
        pt_we    = (st_q == ST_EVICT);
        pt_addr  = (st_q == ST_EVICT) ? e_vpn[vic_q] : cap_vpn_q;
        pt_wdata = {e_ref[vic_q], e_drt[vic_q]};
    end

    // Entry array: fill on ST_FILL, reference/dirty update on a successful lookup
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_val <= '0;
            e_ref <= '0;
            e_drt <= '0;
            e_vpn <= '0;
            e_ppn <= '0;
        end else if (st_q == ST_FILL) begin
            e_val[vic_q] <= 1'b1;
            e_vpn[vic_q] <= cap_vpn_q;
            e_ppn[vic_q] <= pte_q[PPN_W-1:0];
            e_ref[vic_q] <= pte_q[REF_B];
            e_drt[vic_q] <= pte_q[DRT_B];
        end else if (lookup_ok) begin
            e_ref[m_idx] <= 1'b1;
            if (wr_flag) e_drt[m_idx] <= 1'b1;
        end
    end

    // Miss-service controller and registered response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            cap_vpn_q  <= '0;
            cap_wr_q   <= 1'b0;
            vic_q      <= '0;
            vic_free_q <= 1'b0;
            pte_q      <= '0;
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_fault  <= 1'b0;
            rsp_ppn    <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (accept && m_hit) begin
                        rsp_valid <= 1'b1;
                        rsp_hit   <= 1'b1;
                        rsp_fault <= 1'b0;
                        rsp_ppn   <= e_ppn[m_idx];
                    end else if (accept) begin
                        cap_vpn_q  <= req_vpn;
                        cap_wr_q   <= req_write;
                        vic_q      <= v_idx;
                        vic_free_q <= v_free;
                        st_q       <= ST_READ;
                    end
                end
                ST_READ: begin
                    if (pt_ack) begin
                        pte_q <= pt_rdata;
                        if (!pt_rdata[RES_B]) begin
                            rsp_valid <= 1'b1;
                            rsp_hit   <= 1'b0;
                            rsp_fault <= 1'b1;
                            rsp_ppn   <= '0;
                            st_q      <= ST_IDLE;
                        end else begin
                            st_q <= vic_free_q ? ST_FILL : ST_EVICT;
                        end
                    end
                end
                ST_EVICT: begin
                    if (pt_ack) st_q <= ST_FILL;
                end
                ST_FILL: begin
                    st_q <= ST_RETRY;
                end
                ST_RETRY: begin
                    rsp_valid <= 1'b1;
                    rsp_hit   <= 1'b0;
                    rsp_fault <= 1'b0;
                    rsp_ppn   <= e_ppn[m_idx];
                    st_q      <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/tlb_xlate_chk.sv
// Protocol checker for tlb_xlate, attached by bind.
// Assumes the same parameters as the instance it observes.
module tlb_xlate_chk #(
    parameter int unsigned N     = 4,
    parameter int unsigned VPN_W = 8,
    parameter int unsigned PPN_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [VPN_W-1:0] req_vpn,
    input logic             req_write,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic [PPN_W-1:0] rsp_ppn,
    input logic             rsp_hit,
    input logic             rsp_fault,
    input logic             pt_req,
    input logic             pt_we,
    input logic [VPN_W-1:0] pt_addr,
    input logic [1:0]       pt_wdata,
    input logic             pt_ack,
    input logic [PPN_W+2:0] pt_rdata
);

    // A response is never both a hit and a fault
    assert_hit_or_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $onehot0({rsp_hit, rsp_fault}));

    // A fault response follows a completed page-table read
    assert_fault_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> $past(pt_req && pt_ack && !pt_we));

    // A hit response follows an accepted request one cycle earlier
    assert_hit_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> $past(req_valid && req_ready));

    // No new request is taken while the page table is being accessed
    assert_busy_during_walk_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pt_req |-> !req_ready);

    // Page-table request held steady until acknowledged
    assert_pt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_req && !pt_ack) |=> (pt_req && $stable(pt_addr) && $stable(pt_we)));

endmodule

bind tlb_xlate tlb_xlate_chk #(.N(N), .VPN_W(VPN_W), .PPN_W(PPN_W)) chk_i (.*);

// File: tb/tlb_xlate_tb_top.sv
// Self-checking bench: reference model of the cache and page table,
// random and directed translate requests, responding page-table memory.
module tlb_xlate_tb_top;

    localparam int N     = 4;
    localparam int VW    = 8;
    localparam int PW    = 6;
    localparam int PTEW  = PW + 3;
    localparam int DEPTH = 1 << VW;
    localparam int LAT   = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [VW-1:0]   req_vpn = '0;
    logic            req_write = 1'b0;
    logic            req_ready;
    logic            rsp_valid;
    logic [PW-1:0]   rsp_ppn;
    logic            rsp_hit;
    logic            rsp_fault;
    logic            pt_req;
    logic            pt_we;
    logic [VW-1:0]   pt_addr;
    logic [1:0]      pt_wdata;
    logic            pt_ack = 1'b0;
    logic [PTEW-1:0] pt_rdata = '0;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    tlb_xlate #(.N(N), .VPN_W(VW), .PPN_W(PW)) dut_i (.*);

    // Page-table contents: actual memory and expected image
    logic [PTEW-1:0] mem    [DEPTH];
    logic [PTEW-1:0] exp_pt [DEPTH];
    int act_writes = 0;
    int exp_writes = 0;

    // Reference model of the entry array
    logic          m_val [N];
    logic [VW-1:0] m_vpn [N];
    logic [PW-1:0] m_ppn [N];
    logic          m_ref [N];
    logic          m_drt [N];
    int            m_rr;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // Page-table memory: answers after LAT cycles, checks request stability (R9)
    logic [VW-1:0] held_addr;
    logic          held_we;
    int            pend = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            pt_ack = 1'b0;
            pend   = 0;
        end else if (pt_ack) begin
            pt_ack = 1'b0;
            pend   = 0;
        end else if (pt_req) begin
            if (pend == 0) begin
                held_addr = pt_addr;
                held_we   = pt_we;
            end
            pend++;
            if (pend == LAT) begin
                chk(held_addr == pt_addr && held_we == pt_we, "R9 request held",
                    int'(pt_addr), int'(held_addr));
                pt_ack = 1'b1;
                if (pt_we) begin
                    mem[pt_addr][PW+1:PW] = pt_wdata;
                    act_writes++;
                end else begin
                    pt_rdata = mem[pt_addr];
                end
            end
        end
    end

    function automatic void model_reset();
        for (int i = 0; i < N; i++) begin
            m_val[i] = 1'b0;
            m_ref[i] = 1'b0;
            m_drt[i] = 1'b0;
        end
        m_rr = 0;
    endfunction

    // Expected outcome of one translation; updates the model (R1..R6)
    function automatic void model_xlate(input logic [VW-1:0] vpn, input bit wr,
                                        output bit e_hit, output bit e_fault,
                                        output logic [PW-1:0] e_ppn);
        int hi = -1;
        int vi = -1;
        for (int i = 0; i < N; i++) if (m_val[i] && m_vpn[i] == vpn && hi < 0) hi = i;
        e_hit = 1'b0; e_fault = 1'b0; e_ppn = '0;
        if (hi >= 0) begin
            e_hit = 1'b1;
        end else if (!exp_pt[vpn][PW+2]) begin
            e_fault = 1'b1;
            return;
        end else begin
            for (int i = N - 1; i >= 0; i--) if (!m_val[i]) vi = i;
            if (vi < 0) begin
                vi = m_rr;
                m_rr = (m_rr + 1) % N;
                exp_pt[m_vpn[vi]][PW+1:PW] = {m_ref[vi], m_drt[vi]};
                exp_writes++;
            end
            m_val[vi] = 1'b1;
            m_vpn[vi] = vpn;
            m_ppn[vi] = exp_pt[vpn][PW-1:0];
            m_ref[vi] = exp_pt[vpn][PW+1];
            m_drt[vi] = exp_pt[vpn][PW];
            hi = vi;
        end
        m_ref[hi] = 1'b1;
        if (wr) m_drt[hi] = 1'b1;
        e_ppn = m_ppn[hi];
    endfunction

    // Drive one request, hold junk on the inputs while busy, check the response
    task automatic xlate(input logic [VW-1:0] vpn, input bit wr, input string note);
        bit e_hit, e_fault;
        logic [PW-1:0] e_ppn;
        int waited = 0;
        string tag;
        model_xlate(vpn, wr, e_hit, e_fault, e_ppn);
        tag = e_hit ? "R1" : (e_fault ? "R3" : "R2");
        @(negedge clk);
        req_valid = 1'b1; req_vpn = vpn; req_write = wr;
        @(negedge clk);
        if (!rsp_valid) begin
            chk(req_ready == 1'b0, "R7 ready low during miss", int'(req_ready), 0);
            req_vpn = vpn ^ 8'h5A; req_write = 1'b1;
        end
        while (!rsp_valid && waited < 100) begin
            @(negedge clk);
            waited++;
        end
        req_valid = 1'b0;
        chk(rsp_valid == 1'b1, {tag, " response ", note}, int'(rsp_valid), 1);
        chk(rsp_hit == e_hit && rsp_fault == e_fault, {tag, " hit/fault ", note},
            int'({rsp_hit, rsp_fault}), int'({e_hit, e_fault}));
        if (!e_fault)
            chk(rsp_ppn == e_ppn, {tag, " ppn ", note}, int'(rsp_ppn), int'(e_ppn));
        if (e_hit)
            chk(waited == 0, "R1 one-cycle latency", waited, 0);
        chk(act_writes == exp_writes, "R5 write-back count", act_writes, exp_writes);
    endtask

    task automatic do_reset();
        req_valid = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
        chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R8 idle after reset",
            int'({req_ready, rsp_valid}), 2);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int bad;
        int w0;
        void'($urandom(32'd2024));
        for (int v = 0; v < DEPTH; v++) begin
            mem[v] = {(v % 5 != 3), 1'($urandom), 1'($urandom), PW'($urandom)};
            exp_pt[v] = mem[v];
        end
        model_reset();
        do_reset();

        // Directed: fill four slots, then displace slot 0 (R6)
        xlate(8'd0, 1'b0, "fill0");
        xlate(8'd1, 1'b1, "fill1");
        xlate(8'd2, 1'b0, "fill2");
        xlate(8'd4, 1'b0, "fill3");
        xlate(8'd1, 1'b0, "hit1");
        xlate(8'd5, 1'b1, "displace slot0");
        xlate(8'd0, 1'b0, "R6 vpn0 was displaced");
        chk(exp_pt[0][PW+1] == 1'b1 && mem[0][PW+1] == 1'b1, "R4 reference written back",
            int'(mem[0][PW+1]), 1);

        // Directed: non-resident page faults twice, no fill, no write (R3)
        w0 = act_writes;
        xlate(8'd3, 1'b1, "fault first");
        xlate(8'd3, 1'b0, "fault again");
        chk(act_writes == w0, "R3 no write on fault", act_writes, w0);

        // Directed: reset with dirty entries cached writes nothing (R8)
        xlate(8'd5, 1'b1, "dirty before reset");
        w0 = act_writes;
        do_reset();
        chk(act_writes == w0, "R8 no write-back at reset", act_writes, w0);
        xlate(8'd5, 1'b0, "R8 miss after reset");

        // Random mix over a small page range
        for (int k = 0; k < 400; k++) begin
            xlate(VW'($urandom_range(0, 11)), 1'($urandom), "random");
        end

        // Whole page table matches the expected image (R4, R5)
        repeat (4) @(negedge clk);
        bad = 0;
        for (int v = 0; v < DEPTH; v++) if (mem[v] !== exp_pt[v]) bad++;
        chk(bad == 0, "R5 page-table image (R4 bits)", bad, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule